// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered Eight-Channel Code Register Bank

This block is the digital front end of an eight-channel output converter. A host drives three slow pins: a serial clock, a serial data line and an active-low load strobe. Bits are shifted in while the load strobe is high. A low pulse on the load strobe decodes the 12-bit command held in the shift register. The command names a channel, a gain-range flag and an 8-bit code, and they are written into that channel's input (staging) register. A fourth pin, an active-low update strobe, moves staged values to the output registers. While the update pin is held low, each load pulse also updates the addressed channel's output at once. While it is high, new values wait in the staging registers until a falling edge on the update pin copies every channel to the outputs at the same time.

All four pins are brought into the system clock domain through a two-flop synchronizer, and their edges are found there. A three-state controller sequences the work. In ST_SHIFT it accepts bits. On a load falling edge it moves to ST_COMMIT, where it holds for exactly one cycle and writes the addressed channel. It then goes unconditionally to ST_RELEASE, where it waits for the load pin to return high and then goes back to ST_SHIFT. The outputs are eight 8-bit codes, packed with channel k at bits [8k+7:8k], and eight range flags, with channel k at bit k.

Top module: `octal_code_bank`

## Requirements
- R1: After reset, every output code and every range flag is zero.
- R2: While the load pin is high, each falling edge of the serial clock shifts one data bit into the shift register, first bit sent = MSB. Command layout: bits [11:9] channel address, bit [8] range flag, bits [7:0] code.
- R3: A low pulse on the load pin writes the code and range flag into the staging register of the channel whose index equals the address field (0 to 7).
- R4: With the update pin held low, a load pulse also changes the addressed channel's outputs, and no other channel's outputs change.
- R5: With the update pin high, a load pulse leaves every output unchanged.
- R6: A falling edge on the update pin copies all eight staging registers to the outputs together.
- R7: A range bit of 1 sets the channel's range flag output (double gain) and 0 clears it (unity gain); the flag moves to the output in the same update as its code.
- R8: When more than 12 bits are shifted before a load pulse, only the last 12 received bits form the command.
- R9: When fewer than 12 bits are shifted before a load pulse, the command is the register's current content: the older bits move up by the number of new bits received.
- R10: Serial clock falling edges that occur while the load pin is low do not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin; bits are taken on its falling edge |
| ser_dat_i | input | 1 | Serial data pin |
| load_n_i | input | 1 | Active-low load strobe |
| upd_n_i | input | 1 | Active-low update strobe |
| code_o | output | 64 | Eight output codes, channel k at [8k+7:8k] |
| gain2_o | output | 8 | Eight range flags, channel k at bit k |

## Verification
The hardest case to reach is the claim that serial clock edges are ignored while the load pin is low (R10). A full 12-bit command written afterwards would hide any stray shift. The stimulus therefore first commits a known command with the update pin low. It then holds the load pin low and toggles the serial clock with data 1. Next it releases the load pin and pulses it again without sending any bit. If a stray shift had happened, the repeated commit would hit a different channel or code. The short-command case (R9) is reached the same way: a partial word is sent on top of a previous command, and the expected channel is worked out from the shifted remainder.

// File: rtl/ocb_pkg.sv
package ocb_pkg;
    typedef enum logic [1:0] {
        ST_SHIFT   = 2'd0,
        ST_COMMIT  = 2'd1,
        ST_RELEASE = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/ocb_sync.sv
module ocb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ocb_shifter.sv
module ocb_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/ocb_chan.sv
module ocb_chan #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stage_wr,
    input  logic          direct_wr,
    input  logic          xfer,
    input  logic [CW-1:0] d_code,
    input  logic          d_rng,
    output logic [CW-1:0] stage_code,
    output logic [CW-1:0] out_code,
    output logic          out_rng
);
    logic stage_rng;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_code <= '0;
            stage_rng  <= 1'b0;
        end else if (stage_wr) begin
            stage_code <= d_code;
            stage_rng  <= d_rng;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_code <= '0;
            out_rng  <= 1'b0;
        end else if (direct_wr) begin
            out_code <= d_code;
            out_rng  <= d_rng;
        end else if (xfer) begin
            out_code <= stage_code;
            out_rng  <= stage_rng;
        end
    end
endmodule

// File: rtl/octal_code_bank.sv
module octal_code_bank #(
    parameter int CODE_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ser_clk_i,
    input  logic                             ser_dat_i,
    input  logic                             load_n_i,
    input  logic                             upd_n_i,
    output logic [(1<<ADDR_W)*CODE_W-1:0]    code_o,
    output logic [(1<<ADDR_W)-1:0]           gain2_o
);
    import ocb_pkg::*;

    localparam int NCH   = 1 << ADDR_W;
    localparam int CMD_W = ADDR_W + 1 + CODE_W;
    localparam int RNG_B = CODE_W;

    // synchronized pins: {upd, load, data, sclk}
    logic [3:0] pins_s;
    ocb_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({upd_n_i, load_n_i, ser_dat_i, ser_clk_i}),
        .q     (pins_s)
    );

    logic sclk_lvl, dat_lvl, load_lvl, upd_lvl;
    assign sclk_lvl = pins_s[0];
    assign dat_lvl  = pins_s[1];
    assign load_lvl = pins_s[2];
    assign upd_lvl  = pins_s[3];

    logic sclk_prev, load_prev, upd_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b1;
            load_prev <= 1'b1;
            upd_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_lvl;
            load_prev <= load_lvl;
            upd_prev  <= upd_lvl;
        end
    end

    logic sclk_fall, load_fall, upd_fall;
    assign sclk_fall = sclk_prev & ~sclk_lvl;
    assign load_fall = load_prev & ~load_lvl;
    assign upd_fall  = upd_prev  & ~upd_lvl;

    // controller: state register
    ctl_state_e state_q, state_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHIFT;
        else        state_q <= state_d;
    end

    // controller: next state and outputs
    logic shift_en, commit;
    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_SHIFT: begin
                shift_en = sclk_fall & load_lvl;
                if (load_fall) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit  = 1'b1;
                state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (load_lvl) state_d = ST_SHIFT;
            end
            default: state_d = ST_SHIFT;
        endcase
    end

    logic [CMD_W-1:0] shreg;
    ocb_shifter #(.W(CMD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (dat_lvl),
        .q        (shreg)
    );

    logic [ADDR_W-1:0] sel;
    logic [CODE_W-1:0] cmd_code;
    logic              cmd_rng;
    assign sel      = shreg[CMD_W-1 -: ADDR_W];
    assign cmd_rng  = shreg[RNG_B];
    assign cmd_code = shreg[CODE_W-1:0];

    logic [NCH*CODE_W-1:0] stage_flat;
    logic [NCH-1:0]        wr_vec;

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            assign wr_vec[ch] = commit && (sel == ADDR_W'(ch));
            ocb_chan #(.CW(CODE_W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .stage_wr   (wr_vec[ch]),
                .direct_wr  (wr_vec[ch] & ~upd_lvl),
                .xfer       (upd_fall),
                .d_code     (cmd_code),
                .d_rng      (cmd_rng),
                .stage_code (stage_flat[ch*CODE_W +: CODE_W]),
                .out_code   (code_o[ch*CODE_W +: CODE_W]),
                .out_rng    (gain2_o[ch])
            );
        end
    endgenerate
endmodule

// File: rtl/ocb_checker.sv
module ocb_checker #(
    parameter int CODE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  ocb_pkg::ctl_state_e                state_q,
    input  logic                               load_fall,
    input  logic                               load_lvl,
    input  logic                               shift_en,
    input  logic                               upd_lvl,
    input  logic                               upd_fall,
    input  logic                               commit,
    input  logic [ADDR_W+CODE_W:0]             shreg,
    input  logic [(1<<ADDR_W)*CODE_W-1:0]      stage_flat,
    input  logic [(1<<ADDR_W)*CODE_W-1:0]      code_o,
    input  logic [(1<<ADDR_W)-1:0]             gain2_o
);
    import ocb_pkg::*;
    localparam int CMD_W = ADDR_W + 1 + CODE_W;

    logic              pend;
    logic [ADDR_W-1:0] pend_sel;
    logic [CODE_W-1:0] pend_code;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_sel  <= '0;
            pend_code <= '0;
        end else begin
            pend      <= (state_q == ST_COMMIT);
            pend_sel  <= shreg[CMD_W-1 -: ADDR_W];
            pend_code <= shreg[CODE_W-1:0];
        end
    end

    assert_commit_follows_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && load_fall) |=> (state_q == ST_COMMIT));

    assert_commit_lasts_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_RELEASE));

    assert_staged_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (stage_flat[pend_sel*CODE_W +: CODE_W] == pend_code));

    assert_no_shift_when_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_lvl |-> !shift_en);

    assert_shreg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(shreg));

    assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_fall && !(commit && !upd_lvl)) |=> ($stable(code_o) && $stable(gain2_o)));

    assert_bulk_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fall && !commit) |=> (code_o == $past(stage_flat)));
endmodule

bind octal_code_bank ocb_checker #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .load_fall  (load_fall),
    .load_lvl   (load_lvl),
    .shift_en   (shift_en),
    .upd_lvl    (upd_lvl),
    .upd_fall   (upd_fall),
    .commit     (commit),
    .shreg      (shreg),
    .stage_flat (stage_flat),
    .code_o     (code_o),
    .gain2_o    (gain2_o)
);

// File: tb/octal_code_bank_bench.sv
module octal_code_bank_bench;
    localparam int CW  = 8;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic ser_clk = 1'b1, ser_dat = 1'b0, load_n = 1'b1, upd_n = 1'b1;
    logic [NCH*CW-1:0] code_o;
    logic [NCH-1:0]    gain2_o;

    int n_chk = 0;
    int n_bad = 0;

    // model state built from the requirements
    logic [11:0]   m_sh = '0;
    logic [CW-1:0] m_in_code [NCH];
    logic          m_in_rng  [NCH];
    logic [CW-1:0] m_out_code[NCH];
    logic          m_out_rng [NCH];

    always #2.5 clk = ~clk;

    octal_code_bank u_octal_code_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .load_n_i  (load_n),
        .upd_n_i   (upd_n),
        .code_o    (code_o),
        .gain2_o   (gain2_o)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_out(input string req);
        logic [NCH*CW-1:0] ec;
        logic [NCH-1:0]    er;
        for (int k = 0; k < NCH; k++) begin
            ec[k*CW +: CW] = m_out_code[k];
            er[k]          = m_out_rng[k];
        end
        n_chk++;
        if (code_o !== ec || gain2_o !== er) begin
            n_bad++;
            $display("FAIL %s: code=%h gain2=%b expected code=%h gain2=%b",
                     req, code_o, gain2_o, ec, er);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_clk(4);
        ser_clk = 1'b0;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        if (load_n) m_sh = {m_sh[10:0], b};
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_load();
        int a;
        load_n = 1'b0;
        wait_clk(4);
        load_n = 1'b1;
        wait_clk(8);
        a = int'(m_sh[11:9]);
        m_in_code[a] = m_sh[7:0];
        m_in_rng[a]  = m_sh[8];
        if (!upd_n) begin
            m_out_code[a] = m_sh[7:0];
            m_out_rng[a]  = m_sh[8];
        end
    endtask

    task automatic set_upd(input logic v);
        if (upd_n && !v) begin
            for (int k = 0; k < NCH; k++) begin
                m_out_code[k] = m_in_code[k];
                m_out_rng[k]  = m_in_rng[k];
            end
        end
        upd_n = v;
        wait_clk(8);
    endtask

    task automatic send_cmd(input logic [2:0] a, input logic r, input logic [7:0] c);
        send_bits({4'h0, a, r, c}, 12);
        pulse_load();
    endtask

    task automatic t_reset();
        check_out("R1");
    endtask

    task automatic t_immediate();
        set_upd(1'b0);
        send_cmd(3'd2, 1'b0, 8'hA5);
        check_out("R4");
    endtask

    task automatic t_all_channels();
        for (int a = 0; a < NCH; a++) begin
            send_cmd(3'(a), a[0], 8'(8'h11 * (a + 1)));
            check_out(a[0] ? "R7" : "R3");
        end
    endtask

    task automatic t_deferred();
        set_upd(1'b1);
        send_cmd(3'd0, 1'b0, 8'h3C);
        send_cmd(3'd5, 1'b1, 8'hF0);
        send_cmd(3'd7, 1'b0, 8'h01);
        check_out("R5");
        set_upd(1'b0);
        check_out("R6");
    endtask

    task automatic t_long();
        send_bits(16'hB000 | {4'h0, 3'd4, 1'b1, 8'h5A}, 16);
        pulse_load();
        check_out("R8");
    endtask

    task automatic t_short();
        send_cmd(3'd1, 1'b0, 8'h4E);
        send_bits(16'h0009, 4);
        pulse_load();
        check_out("R9");
    endtask

    task automatic t_ignore_low();
        send_cmd(3'd6, 1'b0, 8'h77);
        load_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        load_n = 1'b1;
        wait_clk(8);
        m_out_code[6] = m_out_code[6];
        pulse_load();
        check_out("R10");
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) begin
            m_in_code[k] = '0; m_in_rng[k] = 1'b0;
            m_out_code[k] = '0; m_out_rng[k] = 1'b0;
        end
        #1 rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_immediate();
        t_all_channels();
        t_deferred();
        t_long();
        t_short();
        t_ignore_low();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule